// File: doc/BRIEF.md
# Link Frame Transmitter with Primitive Insertion

This block is the transmit half of a serial storage link layer. It takes 32-bit payload Dwords from the transport layer over a valid/ready stream with a last marker. On every clock it drives one 32-bit Dword onto its output, with a tag bit that tells a primitive from data. A frame goes out as a start delimiter, the payload Dwords, a CRC Dword and an end delimiter. While no frame is in flight, the block fills the link with idle primitives. It shortens a run of identical idle primitives with a continuation primitive followed by filler data.

Independent of frame state, a free-running interval timer forces a pair of alignment primitives onto the output at a fixed period, even in the middle of a payload. During those two cycles the payload stream is stalled. Primitive values are symbolic 32-bit codes: ALIGN = 0xA11C0001, SYNC = 0xA11C0002, SOF = 0xA11C0003, EOF = 0xA11C0004, CONT = 0xA11C0005, PAUSE = 0xA11C0006. The filler word is 0x5A5A5A5A, tagged as data.

Top module: `lnk_frame_tx`

## Requirements
- R1: While reset is asserted, the output is ALIGN (0xA11C0001) with the primitive tag set, `pl_ready` is low and `frame_done` is low.
- R2: Counting output cycles from 0 at the first cycle after reset release, cycle k carries ALIGN exactly when k mod ALIGN_GAP is 0 or 1, in every state including mid-frame, and `pl_ready` is low in those cycles.
- R3: With no frame pending, the non-ALIGN output runs SYNC, SYNC, CONT (0xA11C0005), then filler 0x5A5A5A5A tagged as data for as long as idle lasts. An ALIGN pair restarts this sequence from the first SYNC.
- R4: In idle, a non-ALIGN cycle with `pl_valid` high emits SOF (0xA11C0003) with `pl_ready` low. Payload Dwords follow in order, tagged as data, and each is taken in a cycle where `pl_valid` and `pl_ready` are both high.
- R5: Inside a frame, a non-ALIGN cycle with `pl_valid` low emits the PAUSE primitive (0xA11C0006) and consumes no payload.
- R6: After the Dword marked last is taken, the next non-ALIGN Dword is the CRC, tagged as data, and the one after it is EOF (0xA11C0004). `pl_ready` is low in both.
- R7: The CRC is polynomial 0x04C11DB7 with seed 0x52325032, fed MSB first over the payload Dwords only, with no reflection and no final inversion.
- R8: `frame_done` is high for exactly one cycle, the cycle that follows EOF.
- R9: After EOF the block returns to idle. If `pl_valid` is already high, the next non-ALIGN Dword is SOF, with no idle primitive in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_valid | input | 1 | Payload Dword offered |
| pl_data | input | 32 | Payload Dword |
| pl_last | input | 1 | Offered Dword ends the frame |
| pl_ready | output | 1 | Payload Dword taken this cycle when valid |
| out_dword | output | 32 | Transmitted Dword |
| out_is_prim | output | 1 | 1 = primitive, 0 = data |
| frame_done | output | 1 | One-cycle pulse after the end delimiter |

## Verification
The bench runs a 40-Dword frame across an alignment boundary. A design that ignored the timer during frames would show a misplaced ALIGN, and one that kept `pl_ready` high would lose or repeat a payload Dword. A long idle stretch spans an ALIGN pair, which exposes a continuation tracker that never restarts after alignment. Back-to-back frames catch a design that puts a SYNC between EOF and the next SOF. A frame with a payload gap catches a design that emits stale data instead of PAUSE, and one-Dword frames check the CRC and done-pulse timing when the body is as short as it can be.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
  localparam int DWORD_W = 32;

  localparam logic [DWORD_W-1:0] PRIM_ALIGN = 32'hA11C_0001;
  localparam logic [DWORD_W-1:0] PRIM_SYNC  = 32'hA11C_0002;
  localparam logic [DWORD_W-1:0] PRIM_SOF   = 32'hA11C_0003;
  localparam logic [DWORD_W-1:0] PRIM_EOF   = 32'hA11C_0004;
  localparam logic [DWORD_W-1:0] PRIM_CONT  = 32'hA11C_0005;
  localparam logic [DWORD_W-1:0] PRIM_PAUSE = 32'hA11C_0006;
  localparam logic [DWORD_W-1:0] FILL_WORD  = 32'h5A5A_5A5A;

  localparam logic [DWORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [DWORD_W-1:0] CRC_SEED = 32'h5232_5032;

  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_CRC, ST_EOF} tx_state_e;
  typedef enum logic [1:0] {RUN_SYNC, RUN_CONT, RUN_FILL} run_sel_e;
endpackage

// File: rtl/lnk_align_timer.sv
module lnk_align_timer #(
  parameter int GAP = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic align_slot
);
  localparam int CW = $clog2(GAP);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == CW'(GAP - 1)) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign align_slot = (cnt_q < CW'(2));
endmodule

// File: rtl/lnk_idle_run.sv
module lnk_idle_run
  import lnk_tx_pkg::*;
#(
  parameter int REPEAT_N = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     adv,
  output run_sel_e sel
);
  localparam int CW = $clog2(REPEAT_N + 2);
  localparam logic [CW-1:0] LIM = CW'(REPEAT_N + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                     cnt_d = '0;
    else if (adv && cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    if (cnt_q < CW'(REPEAT_N))       sel = RUN_SYNC;
    else if (cnt_q == CW'(REPEAT_N)) sel = RUN_CONT;
    else                             sel = RUN_FILL;
  end
endmodule

// File: rtl/lnk_crc32.sv
module lnk_crc32
  import lnk_tx_pkg::*;
#(
  parameter int                W    = DWORD_W,
  parameter logic [W-1:0]      POLY = CRC_POLY,
  parameter logic [W-1:0]      SEED = CRC_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q, crc_d, step;

  always_comb begin
    step = crc_q;
    for (int b = W - 1; b >= 0; b--) begin
      if (step[W-1] ^ din[b]) step = {step[W-2:0], 1'b0} ^ POLY;
      else                    step = {step[W-2:0], 1'b0};
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (init)    crc_d = SEED;
    else if (en) crc_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/lnk_frame_tx.sv
module lnk_frame_tx
  import lnk_tx_pkg::*;
#(
  parameter int ALIGN_GAP = 256,
  parameter int REPEAT_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pl_valid,
  input  logic [DWORD_W-1:0] pl_data,
  input  logic               pl_last,
  output logic               pl_ready,
  output logic [DWORD_W-1:0] out_dword,
  output logic               out_is_prim,
  output logic               frame_done
);
  tx_state_e          state_q, state_d;
  logic               done_q, done_d;
  logic               align_slot;
  logic               crc_init, crc_en;
  logic               run_clr, run_adv;
  run_sel_e           run_sel;
  logic [DWORD_W-1:0] crc_val;

  lnk_align_timer #(.GAP(ALIGN_GAP)) u_align (
    .clk(clk), .rst_n(rst_n), .align_slot(align_slot)
  );

  lnk_idle_run #(.REPEAT_N(REPEAT_N)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(run_clr), .adv(run_adv), .sel(run_sel)
  );

  lnk_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
    .din(pl_data), .crc(crc_val)
  );

  always_comb begin
    state_d     = state_q;
    done_d      = 1'b0;
    out_dword   = FILL_WORD;
    out_is_prim = 1'b0;
    pl_ready    = 1'b0;
    crc_init    = 1'b0;
    crc_en      = 1'b0;
    run_clr     = 1'b0;
    run_adv     = 1'b0;
    if (align_slot) begin
      out_dword   = PRIM_ALIGN;
      out_is_prim = 1'b1;
      run_clr     = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pl_valid) begin
            out_dword   = PRIM_SOF;
            out_is_prim = 1'b1;
            run_clr     = 1'b1;
            crc_init    = 1'b1;
            state_d     = ST_BODY;
          end else begin
            run_adv = 1'b1;
            unique case (run_sel)
              RUN_SYNC: begin out_dword = PRIM_SYNC; out_is_prim = 1'b1; end
              RUN_CONT: begin out_dword = PRIM_CONT; out_is_prim = 1'b1; end
              default:  begin out_dword = FILL_WORD; out_is_prim = 1'b0; end
            endcase
          end
        end
        ST_BODY: begin
          pl_ready = 1'b1;
          if (pl_valid) begin
            out_dword = pl_data;
            crc_en    = 1'b1;
            if (pl_last) state_d = ST_CRC;
          end else begin
            out_dword   = PRIM_PAUSE;
            out_is_prim = 1'b1;
          end
        end
        ST_CRC: begin
          out_dword = crc_val;
          state_d   = ST_EOF;
        end
        default: begin
          out_dword   = PRIM_EOF;
          out_is_prim = 1'b1;
          done_d      = 1'b1;
          state_d     = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign frame_done = done_q;
endmodule

// File: rtl/lnk_frame_tx_chk.sv
module lnk_frame_tx_chk
  import lnk_tx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               pl_valid,
  input logic               pl_ready,
  input logic [DWORD_W-1:0] out_dword,
  input logic               out_is_prim,
  input logic               frame_done
);
  logic is_align, is_eof, is_sof, is_sync, is_cont;
  assign is_align = out_is_prim && out_dword == PRIM_ALIGN;
  assign is_eof   = out_is_prim && out_dword == PRIM_EOF;
  assign is_sof   = out_is_prim && out_dword == PRIM_SOF;
  assign is_sync  = out_is_prim && out_dword == PRIM_SYNC;
  assign is_cont  = out_is_prim && out_dword == PRIM_CONT;

  a_r2_align_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    is_align |-> !pl_ready);
  a_r2_align_paired: assert property (@(posedge clk) disable iff (!rst_n)
    (is_align && !$past(is_align)) |=> is_align);
  a_r3_cont_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    is_cont |-> $past(is_sync));
  a_r4_sof_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    is_sof |-> !pl_ready);
  a_r4_take_is_data: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready) |-> !out_is_prim);
  a_r8_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    is_eof |=> frame_done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind lnk_frame_tx lnk_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_ready(pl_ready),
  .out_dword(out_dword), .out_is_prim(out_is_prim), .frame_done(frame_done)
);

// File: tb/lnk_frame_tx_tb.sv
module lnk_frame_tx_tb;
  localparam int GAP    = 32;
  localparam int NF     = 6;
  localparam int GAPLEN = 3;
  localparam int LOGN   = 4096;

  localparam logic [31:0] K_ALIGN = 32'hA11C_0001;
  localparam logic [31:0] K_SYNC  = 32'hA11C_0002;
  localparam logic [31:0] K_SOF   = 32'hA11C_0003;
  localparam logic [31:0] K_EOF   = 32'hA11C_0004;
  localparam logic [31:0] K_CONT  = 32'hA11C_0005;
  localparam logic [31:0] K_PAUSE = 32'hA11C_0006;
  localparam logic [31:0] K_FILL  = 32'h5A5A_5A5A;
  localparam logic [31:0] K_POLY  = 32'h04C1_1DB7;
  localparam logic [31:0] K_SEED  = 32'h5232_5032;

  // frame table: payload length, idle cycles before, payload gap position (0 = none)
  localparam int LEN  [NF] = '{1, 3, 40, 5, 2, 8};
  localparam int IDLE [NF] = '{8, 0, 40, 0, 1, 20};
  localparam int GAPAT[NF] = '{0, 2, 10, 0, 0, 4};

  logic clk = 1'b0;
  logic rst_n, pl_valid, pl_last, pl_ready, out_is_prim, frame_done;
  logic [31:0] pl_data, out_dword;

  always #10 clk = ~clk;

  lnk_frame_tx #(.ALIGN_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_last(pl_last), .pl_ready(pl_ready), .out_dword(out_dword),
    .out_is_prim(out_is_prim), .frame_done(frame_done)
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  int idx = 0;
  bit prev_eof = 1'b0;
  logic [31:0] log_dw [LOGN];
  bit log_pr [LOGN];
  bit log_al [LOGN];
  bit log_rd [LOGN];

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, idx);
    end
  endtask

  function automatic logic [31:0] pay(int f, int w);
    return {8'hD0 + 8'(f), 8'h5E, 16'(w * 37 + 3)};
  endfunction

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic [31:0] d);
    for (int b = 31; b >= 0; b--) begin
      logic fb;
      fb = c[31] ^ d[b];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ K_POLY;
    end
    return c;
  endfunction

  // per-cycle monitor: alignment placement (R2) and done pulse (R8)
  always @(negedge clk) begin
    if (mon_on && idx < LOGN) begin
      bit al;
      al = out_is_prim && out_dword == K_ALIGN;
      chk(al == ((idx % GAP) < 2), "R2 align position", {31'd0, al}, {31'd0, (idx % GAP) < 2});
      if (al) chk(!pl_ready, "R2 ready low during align", {31'd0, pl_ready}, 32'd0);
      if (frame_done || prev_eof)
        chk(frame_done == prev_eof, "R8 done follows EOF", {31'd0, frame_done}, {31'd0, prev_eof});
      prev_eof = out_is_prim && out_dword == K_EOF;
      log_dw[idx] = out_dword;
      log_pr[idx] = out_is_prim;
      log_al[idx] = al;
      log_rd[idx] = pl_ready;
      idx++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pl_valid = 1'b0; pl_last = 1'b0; pl_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_is_prim && out_dword == K_ALIGN, "R1 reset output", out_dword, K_ALIGN);
    chk(!pl_ready, "R1 reset ready", {31'd0, pl_ready}, 32'd0);
    chk(!frame_done, "R1 reset done", {31'd0, frame_done}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_on = 1'b1;

    for (int f = 0; f < NF; f++) begin
      int w;
      bit gapped;
      pl_valid = 1'b0; pl_last = 1'b0;
      repeat (IDLE[f]) begin @(posedge clk); #1; end
      w = 0; gapped = 1'b0;
      while (w < LEN[f]) begin
        bit acc;
        if (GAPAT[f] != 0 && w == GAPAT[f] && !gapped) begin
          pl_valid = 1'b0;
          repeat (GAPLEN) begin @(posedge clk); #1; end
          gapped = 1'b1;
        end
        pl_valid = 1'b1; pl_data = pay(f, w); pl_last = (w == LEN[f] - 1);
        @(negedge clk); acc = pl_ready;
        @(posedge clk); #1;
        if (acc) w++;
      end
      pl_valid = 1'b0; pl_last = 1'b0;
    end
    repeat (40) begin @(posedge clk); #1; end
    mon_on = 1'b0;

    // parse the logged stream against the frame table
    begin
      int mode, run, f, w, idl, pauses;
      bit mid_al;
      logic [31:0] crc, ex;
      bit exp_pr;
      mode = 0; run = 0; f = 0; w = 0; idl = 0; pauses = 0; mid_al = 0; crc = K_SEED;
      for (int i = 0; i < idx; i++) begin
        if (log_al[i]) begin
          run = 0;
          if (mode == 1) mid_al = 1;
        end else begin
          case (mode)
            0: begin
              if (log_pr[i] && log_dw[i] == K_SOF) begin
                chk(!log_rd[i], "R4 SOF ready low", {31'd0, log_rd[i]}, 32'd0);
                if (f > 0 && IDLE[f] == 0)
                  chk(idl == 0, "R9 back-to-back SOF", idl, 0);
                mode = 1; w = 0; pauses = 0; crc = K_SEED;
              end else begin
                ex = (run < 2) ? K_SYNC : (run == 2) ? K_CONT : K_FILL;
                exp_pr = (run < 3);
                chk(log_dw[i] == ex && log_pr[i] == exp_pr, "R3 idle sequence", log_dw[i], ex);
                if (run < 3) run++;
                idl++;
              end
            end
            1: begin
              if (log_pr[i] && log_dw[i] == K_PAUSE) pauses++;
              else begin
                chk(!log_pr[i] && log_dw[i] == pay(f, w), "R4 payload order", log_dw[i], pay(f, w));
                crc = crc_upd(crc, pay(f, w));
                w++;
                if (w == LEN[f]) begin
                  chk((GAPAT[f] != 0) == (pauses > 0), "R5 pause on gap", pauses, GAPAT[f]);
                  mode = 2;
                end
              end
            end
            2: begin
              chk(!log_pr[i] && log_dw[i] == crc, "R6 R7 CRC dword", log_dw[i], crc);
              chk(!log_rd[i], "R6 ready low on CRC", {31'd0, log_rd[i]}, 32'd0);
              mode = 3;
            end
            default: begin
              chk(log_pr[i] && log_dw[i] == K_EOF, "R6 EOF after CRC", log_dw[i], K_EOF);
              mode = 0; run = 0; idl = 0; f++;
            end
          endcase
        end
      end
      chk(f == NF, "R9 all frames completed", f, NF);
      chk(mid_al, "R2 align inside frame", {31'd0, mid_al}, 32'd1);
    end

    // directed: reset taken in the middle of a frame
    pl_valid = 1'b1; pl_data = 32'h0; pl_last = 1'b0;
    repeat (5) begin @(posedge clk); #1; end
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_is_prim && out_dword == K_ALIGN, "R1 reset mid-frame output", out_dword, K_ALIGN);
    chk(!pl_ready, "R1 reset mid-frame ready", {31'd0, pl_ready}, 32'd0);
    chk(!frame_done, "R1 reset mid-frame done", {31'd0, frame_done}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule